// File: doc/BRIEF.md
# ACPI Power-Management Timer and Event Block

This block is a small I/O-mapped power-management unit. A free-running up-counter advances on a clock-enable tick that stands for the roughly 3.58 MHz PM timer rate. Software reads the counter through a 32-bit register. The counter sets a status flag each time it crosses a half-range boundary, so with the default 24-bit width that happens when bit 23 toggles. Three external event sources are also latched as status flags, each arriving as a one-cycle pulse: an RTC alarm, a power button press and a global event.

Each status flag has a matching bit in an enable register. A flag stays set until software writes a 1 to it. The interrupt output `sci` is a level. It is high while any latched event is also enabled.

A control register holds a sleep type field. Writing the control register with the suspend-enable bit set fires a single request pulse. Sleep type 0 produces a soft power-off request, and any other sleep type produces a sleep request. The register window is 64 bytes of I/O space. Its base comes from a configuration word, and a configuration enable bit gates all decoding.

Top module: `pm_event_unit`

## Requirements
- R1: After reset the status, enable and control registers and the timer all read 0, and `sci`, `off_req` and `sleep_req` are low.
- R2: The timer is a TMR_W-bit counter that advances by one on each clock where `tick_en` is high and otherwise holds. It wraps modulo 2^TMR_W. It is read at offset 0x08 with all bits above TMR_W-1 reading 0, and writes to it are ignored.
- R3: Status bit 0 (timer overflow) sets when the counter reaches the armed boundary. The armed boundary is always a multiple of 2^(TMR_W-1), and after reset it is 2^(TMR_W-1).
- R4: Writing 1 to status bit 0 while it is set clears it and re-arms the boundary to the next multiple of 2^(TMR_W-1) strictly above the current count, wrapping at 2^TMR_W. Writing 1 to it while it is clear leaves the armed boundary unchanged.
- R5: Three status bits each set on a one-cycle pulse of their own input and then hold: bit 10 on `rtc_evt`, bit 8 on `pwrbtn_evt` and bit 5 on `glb_evt`.
- R6: The status register at offset 0x00 is write-1-to-clear, and writing 0 to a bit has no effect. An event arriving in the same cycle as a clear of its bit leaves the bit set. All status bits other than 0, 5, 8 and 10 read 0.
- R7: The enable register at offset 0x02 stores and reads back all 16 written bits. It uses the same bit positions as the status register.
- R8: `sci` is high exactly when status AND enable has bit 0, 5, 8 or 10 set.
- R9: The control register at offset 0x04 stores every written bit except bit 13, which always reads 0. Output `sleep_type` follows control bits 11:10.
- R10: A control write with bit 13 = 1 and bits 11:10 = 0 raises `off_req` for exactly the one cycle after the write. A control write with bit 13 = 1 and a nonzero 11:10 raises `sleep_req` for one cycle instead. A control write with bit 13 = 0 raises neither.
- R11: An access hits only when `cfg_dec_en` is 1 and address AND 0xFFC0 equals `cfg_base` AND 0xFFC0. A miss leaves `io_sel` low, makes `io_rdata` read 0 and ignores writes. Unused offsets inside the window read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | PM timer advance strobe |
| cfg_base | input | 16 | I/O base word, low 6 bits ignored |
| cfg_dec_en | input | 1 | Decode enable (bit 0 of the configuration enable byte) |
| io_addr | input | 16 | I/O byte address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 32 | Read data, combinational, 0 when not selected |
| io_sel | output | 1 | Access falls inside the enabled window |
| rtc_evt | input | 1 | RTC alarm pulse |
| pwrbtn_evt | input | 1 | Power button pulse |
| glb_evt | input | 1 | Global event pulse |
| sci | output | 1 | Level interrupt |
| off_req | output | 1 | One-cycle soft power-off request |
| sleep_req | output | 1 | One-cycle sleep request |
| sleep_type | output | 2 | Current sleep type field |

## Verification
The bench targets the overflow re-arm rule. It clears the flag early, late and after a full missed wrap, and it writes a clear while the flag is already clear. A design that re-armed from the last boundary, or re-armed on a clear of a clear flag, would raise the flag one half-period early or late. It also drives an event pulse in the same cycle as a write that clears that event's bit. A design with clear priority would lose that event and keep `sci` low. The control register is written with the suspend bit under every sleep type. A design that stored bit 13, or emitted a pulse lasting more than one cycle, shows up in the read-back or in the pulse width. The bench also moves the base, misaligns it and disables decoding, to catch writes that leak through from outside the window.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;

    // Event bit positions, shared by status and enable registers
    localparam int EVT_TMR = 0;
    localparam int EVT_GLB = 5;
    localparam int EVT_PWR = 8;
    localparam int EVT_RTC = 10;
    localparam logic [15:0] EVT_MASK = 16'h0521;

    // Control register fields
    localparam int CTL_SUSP    = 13;
    localparam int CTL_TYP_LSB = 10;

    // Register offsets inside the window
    localparam logic [7:0] OFF_STS = 8'h00;
    localparam logic [7:0] OFF_EN  = 8'h02;
    localparam logic [7:0] OFF_CTL = 8'h04;
    localparam logic [7:0] OFF_TMR = 8'h08;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_STS,
        REG_EN,
        REG_CTL,
        REG_TMR
    } reg_sel_e;

    typedef struct packed {
        logic     rd;
        logic     wr;
        reg_sel_e sel;
    } io_req_t;

    function automatic reg_sel_e decode_offset(input logic [7:0] off);
        reg_sel_e r;
        case (off)
            OFF_STS: r = REG_STS;
            OFF_EN:  r = REG_EN;
            OFF_CTL: r = REG_CTL;
            OFF_TMR: r = REG_TMR;
            default: r = REG_NONE;
        endcase
        return r;
    endfunction

    function automatic logic [1:0] sleep_field(input logic [15:0] v);
        return v[CTL_TYP_LSB +: 2];
    endfunction

endpackage

// File: rtl/pm_io_decode.sv
module pm_io_decode
    import pm_evt_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int WIN_BITS = 6
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic              cfg_dec_en,
    output logic              hit,
    output io_req_t           req
);
    localparam logic [ADDR_W-1:0] OFF_MASK  = ADDR_W'((1 << WIN_BITS) - 1);
    localparam logic [ADDR_W-1:0] BASE_MASK = ~OFF_MASK;

    logic [7:0] off8;

    always_comb begin
        hit  = cfg_dec_en && ((io_addr & BASE_MASK) == (cfg_base & BASE_MASK));
        off8 = 8'(io_addr & OFF_MASK);
        req.rd  = hit && io_rd;
        req.wr  = hit && io_wr;
        req.sel = hit ? decode_offset(off8) : REG_NONE;
    end

endmodule

// File: rtl/pm_timer.sv
module pm_timer #(
    parameter int TMR_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             rearm,
    output logic [TMR_W-1:0] cnt,
    output logic             boundary_hit
);
    localparam int MSB = TMR_W - 1;

    logic [TMR_W-1:0] cnt_q;
    logic [TMR_W-1:0] cnt_nxt;
    // The armed boundary is a multiple of 2^MSB, so only its top bit is kept
    logic             arm_q;

    always_comb begin
        cnt_nxt      = tick_en ? cnt_q + TMR_W'(1) : cnt_q;
        boundary_hit = tick_en && (cnt_nxt[MSB-1:0] == '0) && (cnt_nxt[MSB] == arm_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            arm_q <= 1'b1;
        end else begin
            cnt_q <= cnt_nxt;
            if (rearm) begin
                arm_q <= ~cnt_nxt[MSB];
            end
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/pm_status_regs.sv
module pm_status_regs
    import pm_evt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] evt_set,
    input  logic        wr_sts,
    input  logic        wr_en,
    input  logic [15:0] wdata,
    output logic [15:0] sts,
    output logic [15:0] en,
    output logic        tmr_rearm,
    output logic        sci
);
    logic [15:0] en_q;

    for (genvar i = 0; i < 16; i++) begin : g_bit
        if (EVT_MASK[i]) begin : g_evt
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    bit_q <= 1'b0;
                end else if (evt_set[i]) begin
                    bit_q <= 1'b1;
                end else if (wr_sts && wdata[i]) begin
                    bit_q <= 1'b0;
                end
            end
            assign sts[i] = bit_q;
        end else begin : g_rsvd
            assign sts[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (wr_en) begin
            en_q <= wdata;
        end
    end

    assign en        = en_q;
    assign tmr_rearm = wr_sts && wdata[EVT_TMR] && sts[EVT_TMR];
    assign sci       = |(sts & en_q & EVT_MASK);

endmodule

// File: rtl/pm_ctrl_reg.sv
module pm_ctrl_reg
    import pm_evt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_ctl,
    input  logic [15:0] wdata,
    output logic [15:0] ctl,
    output logic        off_req,
    output logic        sleep_req,
    output logic [1:0]  sleep_type
);
    localparam logic [15:0] KEEP_MASK = ~(16'h0001 << CTL_SUSP);

    logic [15:0] ctl_q;
    logic        off_q;
    logic        slp_q;
    logic        go;

    assign go = wr_ctl && wdata[CTL_SUSP];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            off_q <= 1'b0;
            slp_q <= 1'b0;
        end else begin
            off_q <= go && (sleep_field(wdata) == 2'd0);
            slp_q <= go && (sleep_field(wdata) != 2'd0);
            if (wr_ctl) begin
                ctl_q <= wdata & KEEP_MASK;
            end
        end
    end

    assign ctl        = ctl_q;
    assign off_req    = off_q;
    assign sleep_req  = slp_q;
    assign sleep_type = sleep_field(ctl_q);

endmodule

// File: rtl/pm_event_unit.sv
module pm_event_unit
    import pm_evt_pkg::*;
#(
    parameter int TMR_W    = 24,
    parameter int WIN_BITS = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_en,
    input  logic [15:0] cfg_base,
    input  logic        cfg_dec_en,
    input  logic [15:0] io_addr,
    input  logic        io_rd,
    input  logic        io_wr,
    input  logic [15:0] io_wdata,
    output logic [31:0] io_rdata,
    output logic        io_sel,
    input  logic        rtc_evt,
    input  logic        pwrbtn_evt,
    input  logic        glb_evt,
    output logic        sci,
    output logic        off_req,
    output logic        sleep_req,
    output logic [1:0]  sleep_type
);
    io_req_t          req;
    logic             hit;
    logic [TMR_W-1:0] tmr_cnt;
    logic             tmr_hit;
    logic             tmr_rearm;
    logic [15:0]      sts;
    logic [15:0]      en;
    logic [15:0]      ctl;
    logic [15:0]      evt_set;
    logic             wr_sts, wr_en, wr_ctl, rd_ctl;

    pm_io_decode #(.ADDR_W(16), .WIN_BITS(WIN_BITS)) u_dec (
        .io_addr    (io_addr),
        .io_rd      (io_rd),
        .io_wr      (io_wr),
        .cfg_base   (cfg_base),
        .cfg_dec_en (cfg_dec_en),
        .hit        (hit),
        .req        (req)
    );

    assign wr_sts = req.wr && (req.sel == REG_STS);
    assign wr_en  = req.wr && (req.sel == REG_EN);
    assign wr_ctl = req.wr && (req.sel == REG_CTL);
    assign rd_ctl = req.rd && (req.sel == REG_CTL);

    pm_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk          (clk),
        .rst          (rst),
        .tick_en      (tick_en),
        .rearm        (tmr_rearm),
        .cnt          (tmr_cnt),
        .boundary_hit (tmr_hit)
    );

    always_comb begin
        evt_set          = '0;
        evt_set[EVT_TMR] = tmr_hit;
        evt_set[EVT_GLB] = glb_evt;
        evt_set[EVT_PWR] = pwrbtn_evt;
        evt_set[EVT_RTC] = rtc_evt;
    end

    pm_status_regs u_sts (
        .clk       (clk),
        .rst       (rst),
        .evt_set   (evt_set),
        .wr_sts    (wr_sts),
        .wr_en     (wr_en),
        .wdata     (io_wdata),
        .sts       (sts),
        .en        (en),
        .tmr_rearm (tmr_rearm),
        .sci       (sci)
    );

    pm_ctrl_reg u_ctl (
        .clk        (clk),
        .rst        (rst),
        .wr_ctl     (wr_ctl),
        .wdata      (io_wdata),
        .ctl        (ctl),
        .off_req    (off_req),
        .sleep_req  (sleep_req),
        .sleep_type (sleep_type)
    );

    always_comb begin
        io_rdata = '0;
        if (req.rd) begin
            case (req.sel)
                REG_STS: io_rdata = {16'h0, sts};
                REG_EN:  io_rdata = {16'h0, en};
                REG_CTL: io_rdata = {16'h0, ctl};
                REG_TMR: io_rdata = 32'(tmr_cnt);
                default: io_rdata = '0;
            endcase
        end
    end

    assign io_sel = hit && (io_rd || io_wr);

endmodule

// File: rtl/pm_event_unit_chk.sv
module pm_event_unit_chk #(
    parameter int TMR_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_en,
    input logic             cfg_dec_en,
    input logic             io_rd,
    input logic             io_sel,
    input logic [31:0]      io_rdata,
    input logic             rtc_evt,
    input logic [15:0]      sts,
    input logic             wr_sts,
    input logic             rd_ctl,
    input logic [TMR_W-1:0] tmr_cnt,
    input logic             off_req,
    input logic             sleep_req
);
    a_r2_tick_step: assert property (@(posedge clk) disable iff (rst)
        tick_en |=> tmr_cnt == $past(tmr_cnt) + TMR_W'(1));

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(tmr_cnt));

    a_r5_rtc_sets: assert property (@(posedge clk) disable iff (rst)
        rtc_evt |=> sts[10]);

    a_r6_rtc_holds: assert property (@(posedge clk) disable iff (rst)
        (sts[10] && !wr_sts) |=> sts[10]);

    a_r9_susp_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (io_rd && rd_ctl) |-> !io_rdata[13]);

    a_r10_off_single: assert property (@(posedge clk) disable iff (rst)
        off_req |=> !off_req);

    a_r10_sleep_single: assert property (@(posedge clk) disable iff (rst)
        sleep_req |=> !sleep_req);

    a_r10_excl: assert property (@(posedge clk) disable iff (rst)
        !(off_req && sleep_req));

    a_r11_off_window: assert property (@(posedge clk) disable iff (rst)
        !cfg_dec_en |-> (!io_sel && io_rdata == 32'h0));

endmodule

bind pm_event_unit pm_event_unit_chk #(.TMR_W(TMR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick_en    (tick_en),
    .cfg_dec_en (cfg_dec_en),
    .io_rd      (io_rd),
    .io_sel     (io_sel),
    .io_rdata   (io_rdata),
    .rtc_evt    (rtc_evt),
    .sts        (sts),
    .wr_sts     (wr_sts),
    .rd_ctl     (rd_ctl),
    .tmr_cnt    (tmr_cnt),
    .off_req    (off_req),
    .sleep_req  (sleep_req)
);

// File: tb/pm_event_unit_tb_top.sv
module pm_event_unit_tb_top;
    localparam int TW   = 10;
    localparam int MOD  = 1 << TW;
    localparam int HALF = 1 << (TW - 1);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic [15:0] cfg_base = 16'h4000;
    logic        cfg_dec_en = 1'b1;
    logic [15:0] io_addr = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [15:0] io_wdata = '0;
    logic [31:0] io_rdata;
    logic        io_sel;
    logic        rtc_evt = 1'b0, pwrbtn_evt = 1'b0, glb_evt = 1'b0;
    logic        sci, off_req, sleep_req;
    logic [1:0]  sleep_type;

    pm_event_unit #(.TMR_W(TW)) dut_i (
        .clk(clk), .rst(rst), .tick_en(tick_en), .cfg_base(cfg_base),
        .cfg_dec_en(cfg_dec_en), .io_addr(io_addr), .io_rd(io_rd),
        .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .io_sel(io_sel), .rtc_evt(rtc_evt), .pwrbtn_evt(pwrbtn_evt),
        .glb_evt(glb_evt), .sci(sci), .off_req(off_req),
        .sleep_req(sleep_req), .sleep_type(sleep_type)
    );

    always #10 clk = ~clk;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Behavioural model state
    int          m_cnt = 0;
    int          m_arm = HALF;
    bit          m_tsts = 1'b0;
    logic [15:0] m_ev = '0;
    logic [15:0] m_en = '0;
    logic [15:0] acc_base = 16'h4000;
    logic        sel_seen;

    function automatic int next_bound(input int c);
        return (((c / HALF) + 1) * HALF) % MOD;
    endfunction

    function automatic logic [15:0] m_sts();
        return m_ev | {15'h0, m_tsts};
    endfunction

    function automatic logic exp_sci(input logic [15:0] s, input logic [15:0] e);
        return |(s & e & 16'h0521);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    task automatic wr_abs(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd_abs(input logic [15:0] a, output logic [31:0] v);
        io_addr = a; io_rd = 1'b1;
        #1;
        v = io_rdata; sel_seen = io_sel;
        io_rd = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [15:0] off, output logic [31:0] v);
        rd_abs(acc_base + off, v);
    endtask

    task automatic wr_sts(input logic [15:0] d);
        wr_abs(acc_base, d);
        m_ev = m_ev & ~(d & 16'h0520);
        if (m_tsts && d[0]) begin
            m_tsts = 1'b0;
            m_arm = next_bound(m_cnt);
        end
    endtask

    task automatic wr_en(input logic [15:0] d);
        wr_abs(acc_base + 16'h2, d);
        m_en = d;
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            tick_en = 1'b1;
            repeat (n) begin
                @(negedge clk);
                m_cnt = (m_cnt + 1) % MOD;
                if (m_cnt == m_arm) m_tsts = 1'b1;
            end
            tick_en = 1'b0;
        end
    endtask

    task automatic pulse(input logic r, input logic p, input logic g);
        @(negedge clk);
        rtc_evt = r; pwrbtn_evt = p; glb_evt = g;
        @(negedge clk);
        rtc_evt = 1'b0; pwrbtn_evt = 1'b0; glb_evt = 1'b0;
        if (r) m_ev[10] = 1'b1;
        if (p) m_ev[8] = 1'b1;
        if (g) m_ev[5] = 1'b1;
    endtask

    task automatic chk_state(input string req);
        logic [31:0] v;
        rd(16'h0, v);
        chk(req, v, {16'h0, m_sts()});
        chk(req, {31'h0, sci}, {31'h0, exp_sci(m_sts(), m_en)});
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog act=timeout exp=finish");
        summary();
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(16'h0, v); chk("R1 status", v, 32'h0);
        rd(16'h2, v); chk("R1 enable", v, 32'h0);
        rd(16'h4, v); chk("R1 control", v, 32'h0);
        rd(16'h8, v); chk("R1 timer", v, 32'h0);
        chk("R1 sci/off/sleep", {29'h0, sci, off_req, sleep_req}, 32'h0);

        // R2 counting, read-only timer, upper bits zero
        ticks(100);
        rd(16'h8, v); chk("R2 timer count", v, 32'd100);
        wr_abs(acc_base + 16'h8, 16'hFFFF);
        rd(16'h8, v); chk("R2 timer write ignored", v, 32'd100);

        // R3 first boundary at HALF
        ticks(HALF - 1 - 100);
        rd(16'h0, v); chk("R3 before boundary", v, 32'h0);
        ticks(1);
        rd(16'h0, v); chk("R3 at boundary", v, 32'h1);
        chk("R8 sci masked", {31'h0, sci}, 32'h0);

        // R7 / R8 enable
        wr_en(16'h0001);
        rd(16'h2, v); chk("R7 enable readback", v, 32'h1);
        chk("R8 sci on timer", {31'h0, sci}, 32'h1);

        // R6 write 0 no effect, write 1 clears
        wr_sts(16'h0000);
        rd(16'h0, v); chk("R6 write zero", v, 32'h1);
        wr_sts(16'h0001);
        rd(16'h0, v); chk("R6 w1c", v, 32'h0);
        chk("R8 sci drops", {31'h0, sci}, 32'h0);

        // R4 rearm after clear at HALF: next boundary is wrap
        ticks(HALF - 1);
        rd(16'h0, v); chk("R4 before wrap", v, 32'h0);
        ticks(1);
        rd(16'h0, v); chk("R4 at wrap", v, 32'h1);
        ticks(100);
        wr_sts(16'h0001);
        ticks(HALF - 101);
        rd(16'h0, v); chk("R4 late clear not early", v, 32'h0);
        ticks(1);
        rd(16'h0, v); chk("R4 late clear boundary", v, 32'h1);
        // clear of a clear flag must not re-arm
        wr_sts(16'h0001);
        ticks(10);
        wr_sts(16'h0001);
        chk_state("R4 clear-of-clear");
        for (int k = 0; k < 8; k++) begin
            ticks(1 + int'($urandom % (2 * HALF)));
            chk_state("R4 random interval");
            if ($urandom % 2 == 1) wr_sts(16'h0001);
        end

        // R5 event latches
        wr_sts(16'h0001);
        pulse(1'b1, 1'b0, 1'b0);
        repeat (5) @(negedge clk);
        chk_state("R5 rtc hold");
        pulse(1'b0, 1'b1, 1'b0);
        pulse(1'b0, 1'b0, 1'b1);
        chk_state("R5 pwr glb");
        wr_en(16'h0400); chk_state("R8 rtc enabled");
        wr_en(16'h0020); chk_state("R8 glb enabled");
        wr_sts(16'hFFFE);
        chk_state("R6 clear all events");

        // R6 event wins over simultaneous clear
        wr_en(16'h0400);
        pulse(1'b1, 1'b0, 1'b0);
        @(negedge clk);
        rtc_evt = 1'b1; io_addr = acc_base; io_wdata = 16'h0400; io_wr = 1'b1;
        @(negedge clk);
        rtc_evt = 1'b0; io_wr = 1'b0;
        rd(16'h0, v); chk("R6 set beats clear", v & 32'h0400, 32'h0400);
        chk("R6 sci stays", {31'h0, sci}, 32'h1);
        wr_sts(16'h0400);

        // R9 / R10 control
        wr_abs(acc_base + 16'h4, 16'h2000);
        chk("R10 off pulse", {30'h0, off_req, sleep_req}, 32'h2);
        @(negedge clk);
        chk("R10 off one cycle", {31'h0, off_req}, 32'h0);
        rd(16'h4, v); chk("R9 bit13 zero", v, 32'h0);
        wr_abs(acc_base + 16'h4, 16'h2C01);
        chk("R10 sleep pulse", {30'h0, off_req, sleep_req}, 32'h1);
        chk("R9 sleep_type", {30'h0, sleep_type}, 32'h3);
        @(negedge clk);
        chk("R10 sleep one cycle", {31'h0, sleep_req}, 32'h0);
        rd(16'h4, v); chk("R9 ctl readback", v, 32'h0C01);
        wr_abs(acc_base + 16'h4, 16'h0401);
        chk("R10 no pulse bit13 clear", {30'h0, off_req, sleep_req}, 32'h0);
        chk("R9 sleep_type 1", {30'h0, sleep_type}, 32'h1);
        wr_abs(acc_base + 16'h4, 16'hFFFF);
        chk("R10 sleep on ones", {30'h0, off_req, sleep_req}, 32'h1);
        rd(16'h4, v); chk("R9 ones readback", v, 32'hDFFF);

        // R11 decode
        rd(16'h6, v); chk("R11 unused offset", v, 32'h0);
        rd(16'h3E, v); chk("R11 top of window sel", {31'h0, sel_seen}, 32'h1);
        wr_en(16'h1234);
        cfg_dec_en = 1'b0;
        rd(16'h2, v); chk("R11 disabled read", {v[30:0], sel_seen}, 32'h0);
        wr_abs(acc_base + 16'h2, 16'hFFFF);
        cfg_dec_en = 1'b1;
        rd(16'h2, v); chk("R11 disabled write ignored", v, 32'h1234);
        cfg_base = 16'h4025;
        rd(16'h2, v); chk("R11 base low bits ignored", v, 32'h1234);
        wr_abs(16'h4042, 16'hFFFF);
        rd_abs(16'h4042, v); chk("R11 outside window", {v[30:0], sel_seen}, 32'h0);
        rd(16'h2, v); chk("R11 outside write ignored", v, 32'h1234);
        cfg_base = 16'h9A80; acc_base = 16'h9A80;
        rd(16'h2, v); chk("R11 moved base", v, 32'h1234);

        // Random mix of events, enables, clears and ticks
        for (int it = 0; it < 250; it++) begin
            case ($urandom % 4)
                0: pulse(1'($urandom), 1'($urandom), 1'($urandom));
                1: wr_en(16'($urandom));
                2: wr_sts(16'($urandom));
                default: ticks(1 + int'($urandom % 300));
            endcase
            chk_state("R8 random");
        end

        summary();
    end

endmodule